// File: doc/BRIEF.md
# Addressed Single-Byte I2C Transfer Sequencer

This block runs one complete register access on an I2C target by commanding a byte-level master engine. The engine reports progress through a status code. A request names the direction, a 7-bit target address, an 8-bit register index and, for writes, one data byte. The sequencer then steps the engine through the bus phases. After each phase it polls the engine's phase-complete flag under a timeout and compares the reported status against the one value that phase must produce. It returns one result byte, which is zero on success, and for reads the byte that was received.

Every transaction is enclosed in a guarded STOP. The sequencer commands STOP, then waits in turn for the engine's stop-pending indication to drop, for the idle status 0xF8 and for the line-state value 0x3A. Each of these waits has its own time limit. The same guarded STOP closes the transaction, whether it succeeded or aborted. An abort happens at the first failing phase and yields a code that identifies both the phase and the kind of failure. The engine contract is as follows: a command is a one-cycle pulse, and the engine drops its phase-complete flag at the clock edge that takes a non-STOP command.

Top module: `i2c_reg_byte_seq`

## Requirements
- R1: After reset, busy, done, eng_cmd_valid, result and rdata are all 0.
- R2: A request with req_valid high while busy is low is taken at that clock edge, and busy is high from the next cycle until the closing STOP finishes. done is a one-cycle pulse in the first cycle busy is low again, and result is held while idle. A request presented while busy is ignored.
- R3: Each transaction starts with a guarded STOP (eng_cmd 1). If eng_status is not 0xF8 when it finishes, result is 0xF8 and no other command follows before the closing STOP.
- R4: A write issues START (expect status 0x08), then sends the write address byte (0x18), the register index (0x28) and the data byte (0x28), and gives result 0x00 when all statuses match.
- R5: A read issues START (0x08), the write address byte (0x18), the register index (0x28), a repeated START (0x10), the read address byte (0x40) and a receive (0x58). It gives result 0x00 and rdata equal to the received byte.
- R6: An address byte carries the target address in bits 7:1, with bit 0 cleared for the write phase and set for the read phase.
- R7: When the status reported with the flag differs from the expected value, the result is that expected value. No further phase command is issued, and the closing STOP follows.
- R8: A flag timeout yields a phase-specific result: 0xFF START, 0xFE write address, 0xFD register index, 0xFC write data, 0xFB repeated START, 0xFA read address, 0xF9 receive.
- R9: After each phase command the flag is sampled in TIMEOUT_LIMIT consecutive cycles. A flag first seen in the last of them still lets the transaction proceed, and a flag seen one cycle later does not.
- R10: In the guarded STOP, no phase command is issued while the stop-pending input is high or the line state differs from 0x3A, unless a wait has run out. Running out of a guarded-STOP wait never changes the result.
- R11: rdata is loaded from eng_rx_byte only in the cycle the receive phase reports its flag, even when the status then mismatches. It is otherwise unchanged.
- R12: Commands use eng_cmd codes 0 START, 1 STOP, 2 SEND (eng_tx_byte), 3 RECEIVE. Each command is a single-cycle eng_cmd_valid pulse, and commands are issued only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction request |
| req_read | input | 1 | 1 for read, 0 for write |
| req_target | input | 7 | Target address |
| req_reg | input | 8 | Register index sent after the address |
| req_wdata | input | 8 | Data byte for writes |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | 0x00 on success, otherwise the failure code |
| rdata | output | 8 | Byte received by the last receive phase |
| eng_cmd_valid | output | 1 | Command pulse to the engine |
| eng_cmd | output | 2 | Command code |
| eng_tx_byte | output | 8 | Byte to send with a SEND command |
| eng_flag | input | 1 | Phase-complete flag |
| eng_status | input | 8 | Engine status code |
| eng_stop_pend | input | 1 | Engine still executing STOP |
| eng_lines | input | 8 | Bus line state code |
| eng_rx_byte | input | 8 | Last received byte |

## Verification
busy is due one cycle after the edge that accepts a request. The bench samples it at the falling edge that follows. result, rdata and done are due together in the first cycle busy is low, so the bench waits for done at falling edges and reads all three in that same half-cycle. The engine model raises its flag a programmed number of edges after a command. Delays of TIMEOUT_LIMIT-1 and TIMEOUT_LIMIT then place the flag exactly in the last polled cycle or one cycle past it. Fault sweeps cover every phase of both directions, with each phase given a wrong status and each phase given a timeout. For each one the bench checks the result code, the full command and byte sequence and the captured read byte.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int TGT_W  = 7;

    localparam logic [BYTE_W-1:0] STAT_BUS_IDLE  = 8'hF8;
    localparam logic [BYTE_W-1:0] LINES_RELEASED = 8'h3A;
    localparam logic [BYTE_W-1:0] RES_OK         = 8'h00;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_STOP  = 2'd1,
        CMD_SEND  = 2'd2,
        CMD_RECV  = 2'd3
    } eng_cmd_e;

    typedef enum logic [2:0] {
        PH_START,
        PH_ADDR_WR,
        PH_REG,
        PH_WDATA,
        PH_RESTART,
        PH_ADDR_RD,
        PH_RDATA
    } phase_e;

    function automatic logic [BYTE_W-1:0] phase_status(input phase_e ph);
        case (ph)
            PH_START:   return 8'h08;
            PH_ADDR_WR: return 8'h18;
            PH_REG:     return 8'h28;
            PH_WDATA:   return 8'h28;
            PH_RESTART: return 8'h10;
            PH_ADDR_RD: return 8'h40;
            PH_RDATA:   return 8'h58;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] phase_tmo_code(input phase_e ph);
        case (ph)
            PH_START:   return 8'hFF;
            PH_ADDR_WR: return 8'hFE;
            PH_REG:     return 8'hFD;
            PH_WDATA:   return 8'hFC;
            PH_RESTART: return 8'hFB;
            PH_ADDR_RD: return 8'hFA;
            PH_RDATA:   return 8'hF9;
            default:    return 8'hFF;
        endcase
    endfunction

    function automatic eng_cmd_e phase_cmd(input phase_e ph);
        case (ph)
            PH_START, PH_RESTART: return CMD_START;
            PH_RDATA:             return CMD_RECV;
            default:              return CMD_SEND;
        endcase
    endfunction

    function automatic phase_e phase_next(input phase_e ph, input logic rd);
        case (ph)
            PH_START:   return PH_ADDR_WR;
            PH_ADDR_WR: return PH_REG;
            PH_REG:     return rd ? PH_RESTART : PH_WDATA;
            PH_RESTART: return PH_ADDR_RD;
            PH_ADDR_RD: return PH_RDATA;
            default:    return PH_START;
        endcase
    endfunction

    function automatic logic phase_final(input phase_e ph, input logic rd);
        return rd ? (ph == PH_RDATA) : (ph == PH_WDATA);
    endfunction

endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic last
);
    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t r_q, r_d;

    assign last = (r_q.cnt == LAST_VAL);

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (tick && !last) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/i2c_seq_stop_guard.sv
module i2c_seq_stop_guard
    import i2c_seq_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              stop_pend,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] lines,
    output logic              cmd_stop,
    output logic              fin
);
    typedef enum logic [2:0] {
        G_IDLE,
        G_ISSUE,
        G_WAIT_STOPBIT,
        G_WAIT_STATUS,
        G_WAIT_LINES
    } gstate_e;

    typedef struct packed {
        gstate_e st;
    } guard_t;

    guard_t r_q, r_d;
    logic   tmr_clr, tmr_tick, tmr_last;

    i2c_seq_timer #(.LIMIT(LIMIT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        cmd_stop = 1'b0;
        fin      = 1'b0;
        case (r_q.st)
            G_IDLE: begin
                if (go) r_d.st = G_ISSUE;
            end
            G_ISSUE: begin
                cmd_stop = 1'b1;
                tmr_clr  = 1'b1;
                r_d.st   = G_WAIT_STOPBIT;
            end
            G_WAIT_STOPBIT: begin
                if (!stop_pend || tmr_last) begin
                    tmr_clr = 1'b1;
                    r_d.st  = G_WAIT_STATUS;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            G_WAIT_STATUS: begin
                if ((status == STAT_BUS_IDLE) || tmr_last) begin
                    tmr_clr = 1'b1;
                    r_d.st  = G_WAIT_LINES;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            G_WAIT_LINES: begin
                if ((lines == LINES_RELEASED) || tmr_last) begin
                    tmr_clr = 1'b1;
                    fin     = 1'b1;
                    r_d.st  = G_IDLE;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            default: r_d.st = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: G_IDLE};
        else        r_q <= r_d;
    end
endmodule

// File: rtl/i2c_reg_byte_seq.sv
module i2c_reg_byte_seq
    import i2c_seq_pkg::*;
#(
    parameter int TIMEOUT_LIMIT = 'h4FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_read,
    input  logic [6:0]  req_target,
    input  logic [7:0]  req_reg,
    input  logic [7:0]  req_wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  result,
    output logic [7:0]  rdata,
    output logic        eng_cmd_valid,
    output logic [1:0]  eng_cmd,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_flag,
    input  logic [7:0]  eng_status,
    input  logic        eng_stop_pend,
    input  logic [7:0]  eng_lines,
    input  logic [7:0]  eng_rx_byte
);
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPEN,
        S_ISSUE,
        S_WAIT,
        S_CLOSE_REQ,
        S_CLOSE
    } state_e;

    typedef struct packed {
        state_e             st;
        phase_e             ph;
        logic               rd;
        logic [TGT_W-1:0]   tgt;
        logic [BYTE_W-1:0]  regb;
        logic [BYTE_W-1:0]  wdat;
        logic [BYTE_W-1:0]  res;
        logic [BYTE_W-1:0]  rdat;
        logic               done;
    } seq_t;

    seq_t r_q, r_d;

    logic guard_go, guard_cmd, guard_fin;
    logic tmr_clr, tmr_tick, tmr_last;
    logic phase_issue;

    i2c_seq_stop_guard #(.LIMIT(TIMEOUT_LIMIT)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (guard_go),
        .stop_pend (eng_stop_pend),
        .status    (eng_status),
        .lines     (eng_lines),
        .cmd_stop  (guard_cmd),
        .fin       (guard_fin)
    );

    i2c_seq_timer #(.LIMIT(TIMEOUT_LIMIT)) u_flag_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .last  (tmr_last)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        guard_go    = 1'b0;
        tmr_clr     = 1'b0;
        tmr_tick    = 1'b0;
        phase_issue = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.rd   = req_read;
                    r_d.tgt  = req_target;
                    r_d.regb = req_reg;
                    r_d.wdat = req_wdata;
                    guard_go = 1'b1;
                    r_d.st   = S_OPEN;
                end
            end
            S_OPEN: begin
                if (guard_fin) begin
                    if (eng_status != STAT_BUS_IDLE) begin
                        r_d.res = STAT_BUS_IDLE;
                        r_d.st  = S_CLOSE_REQ;
                    end else begin
                        r_d.ph = PH_START;
                        r_d.st = S_ISSUE;
                    end
                end
            end
            S_ISSUE: begin
                phase_issue = 1'b1;
                tmr_clr     = 1'b1;
                r_d.st      = S_WAIT;
            end
            S_WAIT: begin
                if (eng_flag) begin
                    if (r_q.ph == PH_RDATA) r_d.rdat = eng_rx_byte;
                    if (eng_status != phase_status(r_q.ph)) begin
                        r_d.res = phase_status(r_q.ph);
                        r_d.st  = S_CLOSE_REQ;
                    end else if (phase_final(r_q.ph, r_q.rd)) begin
                        r_d.res = RES_OK;
                        r_d.st  = S_CLOSE_REQ;
                    end else begin
                        r_d.ph = phase_next(r_q.ph, r_q.rd);
                        r_d.st = S_ISSUE;
                    end
                end else if (tmr_last) begin
                    r_d.res = phase_tmo_code(r_q.ph);
                    r_d.st  = S_CLOSE_REQ;
                end else begin
                    tmr_tick = 1'b1;
                end
            end
            S_CLOSE_REQ: begin
                guard_go = 1'b1;
                r_d.st   = S_CLOSE;
            end
            S_CLOSE: begin
                if (guard_fin) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, ph: PH_START, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.ph)
            PH_ADDR_WR: eng_tx_byte = {r_q.tgt, 1'b0};
            PH_REG:     eng_tx_byte = r_q.regb;
            PH_WDATA:   eng_tx_byte = r_q.wdat;
            PH_ADDR_RD: eng_tx_byte = {r_q.tgt, 1'b1};
            default:    eng_tx_byte = '0;
        endcase
    end

    assign eng_cmd_valid = phase_issue | guard_cmd;
    assign eng_cmd       = guard_cmd ? CMD_STOP : phase_cmd(r_q.ph);
    assign busy          = (r_q.st != S_IDLE);
    assign done          = r_q.done;
    assign result        = r_q.res;
    assign rdata         = r_q.rdat;
endmodule

// File: rtl/i2c_reg_byte_seq_chk.sv
module i2c_reg_byte_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [7:0] result,
    input logic [7:0] rdata,
    input logic       eng_cmd_valid,
    input logic [1:0] eng_cmd,
    input logic       eng_flag
);
    AST_ACCEPT_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);                                   // R2

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));                                 // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R2

    AST_RESULT_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> $stable(result));                            // R2

    AST_OPEN_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (eng_cmd_valid && eng_cmd == 2'd1));              // R3

    AST_RDATA_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> ($past(eng_flag) && $past(busy)));            // R11

    AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |-> busy);                                          // R12

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid |=> !eng_cmd_valid);                                // R12
endmodule

bind i2c_reg_byte_seq i2c_reg_byte_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .result        (result),
    .rdata         (rdata),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd       (eng_cmd),
    .eng_flag      (eng_flag)
);

// File: tb/test_i2c_reg_byte_seq.sv
module test_i2c_reg_byte_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_read = 1'b0;
    logic [6:0] req_target = '0;
    logic [7:0] req_reg = '0, req_wdata = '0;
    logic       busy, done, eng_cmd_valid;
    logic [7:0] result, rdata, eng_tx_byte;
    logic [1:0] eng_cmd;
    logic       eng_flag, eng_stop_pend;
    logic [7:0] eng_status, eng_lines, eng_rx_byte;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_byte_seq #(.TIMEOUT_LIMIT(TMO)) i_i2c_reg_byte_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
        .req_target(req_target), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .result(result), .rdata(rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_tx_byte(eng_tx_byte),
        .eng_flag(eng_flag), .eng_status(eng_status), .eng_stop_pend(eng_stop_pend),
        .eng_lines(eng_lines), .eng_rx_byte(eng_rx_byte)
    );

    // engine model configuration (written by the stimulus only)
    int         cfg_delay = 2;       // edges from command to flag, 0 = never
    int         cfg_stop_delay = 2;  // edges for STOP to finish, 0 = never
    int         cfg_line_delay = 1;  // edges after STOP before lines settle
    logic [7:0] cfg_idle_status = 8'hF8;
    logic [7:0] cfg_rx = 8'h00;
    int         cfg_fault_idx = -1;
    int         cfg_fault_kind = 0;  // 0 wrong status, 1 no flag
    logic [7:0] exp_stat [6];
    logic       mdl_clr = 1'b0;

    // engine model state (written by the model only)
    int         fcnt, scnt, lcnt, n_cmd, n_tx, n_step, early_err, done_cnt;
    logic [7:0] pend_stat;
    logic [1:0] cmd_log [16];
    logic [7:0] tx_log [16];
    logic       m_flag, m_stop;
    logic [7:0] m_status, m_lines, m_rx;

    assign eng_flag      = m_flag;
    assign eng_stop_pend = m_stop;
    assign eng_status    = m_status;
    assign eng_lines     = m_lines;
    assign eng_rx_byte   = m_rx;

    initial begin
        fcnt = 0; scnt = 0; lcnt = 0; n_cmd = 0; n_tx = 0; n_step = 0;
        early_err = 0; done_cnt = 0; pend_stat = 0;
        m_flag = 0; m_stop = 0; m_status = 8'hF8; m_lines = 8'h3A; m_rx = 0;
    end

    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    always @(posedge clk) begin
        if (mdl_clr) begin
            fcnt <= 0; scnt <= 0; lcnt <= 0; n_cmd <= 0; n_tx <= 0; n_step <= 0;
            m_flag <= 0; m_stop <= 0; m_status <= 8'hF8; m_lines <= 8'h3A;
        end else if (eng_cmd_valid) begin
            if (n_cmd < 16) cmd_log[n_cmd] <= eng_cmd;
            n_cmd  <= n_cmd + 1;
            m_flag <= 1'b0;
            if (eng_cmd == 2'd1) begin
                m_stop  <= 1'b1;
                m_lines <= 8'h00;
                scnt    <= cfg_stop_delay;
                fcnt    <= 0;
            end else begin
                if (m_stop || m_lines != 8'h3A) early_err <= early_err + 1;
                if (eng_cmd == 2'd2) begin
                    if (n_tx < 16) tx_log[n_tx] <= eng_tx_byte;
                    n_tx <= n_tx + 1;
                end
                pend_stat <= (n_step == cfg_fault_idx && cfg_fault_kind == 0)
                             ? (exp_stat[n_step] ^ 8'h01) : exp_stat[n_step];
                fcnt <= (n_step == cfg_fault_idx && cfg_fault_kind == 1) ? 0 : cfg_delay;
                n_step <= n_step + 1;
            end
        end else begin
            if (fcnt != 0) begin
                if (fcnt == 1) begin
                    m_flag   <= 1'b1;
                    m_status <= pend_stat;
                    m_rx     <= cfg_rx;
                end
                fcnt <= fcnt - 1;
            end
            if (scnt != 0) begin
                if (scnt == 1) begin
                    m_stop   <= 1'b0;
                    m_status <= cfg_idle_status;
                    if (cfg_line_delay == 0) m_lines <= 8'h3A;
                    else lcnt <= cfg_line_delay;
                end
                scnt <= scnt - 1;
            end
            if (lcnt != 0) begin
                if (lcnt == 1) m_lines <= 8'h3A;
                lcnt <= lcnt - 1;
            end
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_rdata = 8'h00;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // R4 R5 R6 R7 R8 R9 R10 R11 R3: one transaction against the model
    task automatic run_txn(input bit rd, input logic [6:0] tgt, input logic [7:0] rg,
                           input logic [7:0] wd, input logic [7:0] rx,
                           input int fidx, input int fkind, input bit poke,
                           input string req);
        int         nst, fs, fk, steps, dbase, ebase, wait_cyc;
        logic [7:0] exp_res, tmo_c [6], st_c [6], tx_e [6];
        logic [1:0] cmd_e [6];
        nst = rd ? 6 : 4;
        if (rd) begin
            st_c  = '{8'h08, 8'h18, 8'h28, 8'h10, 8'h40, 8'h58};
            tmo_c = '{8'hFF, 8'hFE, 8'hFD, 8'hFB, 8'hFA, 8'hF9};
            cmd_e = '{2'd0, 2'd2, 2'd2, 2'd0, 2'd2, 2'd3};
            tx_e  = '{8'h00, {tgt, 1'b0}, rg, 8'h00, {tgt, 1'b1}, 8'h00};
        end else begin
            st_c  = '{8'h08, 8'h18, 8'h28, 8'h28, 8'h00, 8'h00};
            tmo_c = '{8'hFF, 8'hFE, 8'hFD, 8'hFC, 8'h00, 8'h00};
            cmd_e = '{2'd0, 2'd2, 2'd2, 2'd2, 2'd0, 2'd0};
            tx_e  = '{8'h00, {tgt, 1'b0}, rg, wd, 8'h00, 8'h00};
        end
        fs = fidx; fk = fkind;
        if (cfg_delay == 0 || cfg_delay >= TMO) begin fs = 0; fk = 1; end
        if (cfg_idle_status != 8'hF8) begin
            exp_res = 8'hF8; steps = 0;
        end else if (fs < 0) begin
            exp_res = 8'h00; steps = nst;
        end else begin
            exp_res = fk ? tmo_c[fs] : st_c[fs]; steps = fs + 1;
        end
        if (rd && cfg_idle_status == 8'hF8 && (fs < 0 || (fs == 5 && fk == 0)))
            exp_rdata = rx;
        for (int i = 0; i < 6; i++) exp_stat[i] = st_c[i];
        cfg_fault_idx = fidx; cfg_fault_kind = fkind; cfg_rx = rx;

        @(negedge clk); mdl_clr = 1'b1;
        @(negedge clk); mdl_clr = 1'b0;
        dbase = done_cnt; ebase = early_err;
        req_valid = 1'b1; req_read = rd; req_target = tgt; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R2", "busy one cycle after accept", busy, 1);
        if (poke) begin
            repeat (4) @(negedge clk);
            req_valid = 1'b1; req_read = ~rd; req_target = ~tgt; req_reg = ~rg; req_wdata = ~wd;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_cyc = 0;
        while (!done && wait_cyc < 3000) begin @(negedge clk); wait_cyc++; end
        check(done === 1'b1, req, "done seen", done, 1);
        check(busy === 1'b0, "R2", "busy low with done", busy, 0);
        check(result === exp_res, req, "result", result, exp_res);
        check(rdata === exp_rdata, "R11", "rdata", rdata, exp_rdata);
        check(n_cmd == steps + 2, req, "command count", n_cmd, steps + 2);
        check(cmd_log[0] == 2'd1, "R3", "opening STOP", cmd_log[0], 1);
        check(cmd_log[steps + 1] == 2'd1, "R7", "closing STOP", cmd_log[steps + 1], 1);
        begin
            int k;
            k = 0;
            for (int i = 0; i < steps; i++) begin
                check(cmd_log[i + 1] == cmd_e[i], "R12", "command code", cmd_log[i + 1], cmd_e[i]);
                if (cmd_e[i] == 2'd2) begin
                    check(tx_log[k] == tx_e[i], "R6", "sent byte", tx_log[k], tx_e[i]);
                    k++;
                end
            end
        end
        if (cfg_stop_delay != 0)
            check(early_err == ebase, "R10", "phase command during STOP", early_err - ebase, 0);
        repeat (3) @(negedge clk);
        check(done_cnt - dbase == 1, "R2", "done pulses", done_cnt - dbase, 1);
        check(result === exp_res, "R2", "result held", result, exp_res);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
        check(result === 8'h00, "R1", "result in reset", result, 0);
        check(rdata === 8'h00, "R1", "rdata in reset", rdata, 0);
        check(eng_cmd_valid === 1'b0, "R1", "command in reset", eng_cmd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0, "R1", "idle after reset", busy, 0);

        for (int k = 0; k < 6; k++) begin
            logic [6:0] t;
            logic [7:0] g, w, x;
            t = 7'((k * 37 + 5) & 8'h7F);
            g = 8'(k * 53 + 1); w = 8'(k * 71 + 9); x = 8'(k * 29 + 3);
            run_txn(1'b0, t, g, w, x, -1, 0, 1'b0, "R4");
            run_txn(1'b1, t, g, w, x, -1, 0, 1'b0, "R5");
        end
        run_txn(1'b1, 7'h7F, 8'hFF, 8'h00, 8'hA5, -1, 0, 1'b0, "R6");

        for (int rd = 0; rd < 2; rd++)
            for (int i = 0; i < (rd ? 6 : 4); i++) begin
                run_txn(rd[0], 7'h2C, 8'h41, 8'h9E, 8'(8'h60 + i), i, 0, 1'b0, "R7");
                run_txn(rd[0], 7'h13, 8'h07, 8'h5A, 8'(8'hC0 + i), i, 1, 1'b0, "R8");
            end

        cfg_idle_status = 8'h20;
        run_txn(1'b0, 7'h44, 8'h10, 8'h20, 8'h00, -1, 0, 1'b0, "R3");
        cfg_idle_status = 8'hF8;

        cfg_delay = TMO - 1;
        run_txn(1'b1, 7'h31, 8'h22, 8'h00, 8'h3C, -1, 0, 1'b0, "R9");
        cfg_delay = TMO;
        run_txn(1'b1, 7'h31, 8'h22, 8'h00, 8'h3D, -1, 0, 1'b0, "R9");
        cfg_delay = 2;

        cfg_stop_delay = 6; cfg_line_delay = 4;
        run_txn(1'b0, 7'h0A, 8'h0B, 8'h0C, 8'h00, -1, 0, 1'b0, "R10");
        cfg_stop_delay = 0;
        run_txn(1'b1, 7'h0A, 8'h0B, 8'h0C, 8'h77, -1, 0, 1'b0, "R10");
        cfg_stop_delay = 2; cfg_line_delay = 1;

        run_txn(1'b0, 7'h66, 8'h99, 8'h3C, 8'h00, -1, 0, 1'b1, "R2");
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule